// File: doc/BRIEF.md
# SPI Receive Word Queue with Overrun and Unread-Data Timeout

This block sits between the serial shift logic of an SPI controller and the register-read path. Each time the shift logic completes a word it strobes `push_i` with the word on `push_data_i`. Software reads drain the queue through `pop_i`. The oldest unread word is always visible on `pop_data_o`, and a pop strobe consumes it.

Two sticky conditions are recorded. The overrun flag is raised when a word arrives while every slot is occupied and the read side does not free one in the same cycle. That word is discarded, and the stored words keep their order and contents. The timeout flag is raised when data has sat unread for too long. The limit is 64 clocks when the controller is a master and 576 clocks when it is a slave. Each flag is cleared by a one-cycle write-1 strobe and drives the shared interrupt line only while its enable input is high.

Top module: `rxq_fifo`

## Requirements
- R1: Words leave through `pop_data_o` in the order they were accepted, and `pop_data_o` shows the oldest stored word whenever the queue is not empty. `level_o` gives the number of stored words and never exceeds DEPTH (default 8).
- R2: `full_o` is 1 exactly when `level_o` equals DEPTH. `empty_o` is 1 exactly when `level_o` is 0. After reset the queue is empty and both flags and `irq_o` are 0.
- R3: A push while full, with no pop in the same cycle, is dropped. `ovr_flag_o` is 1 after that clock edge, and the stored words and `level_o` are unchanged.
- R4: A push and a pop in the same cycle while full are both accepted. The queue stays full and `ovr_flag_o` is not set.
- R5: With `slave_mode_i` = 0 (master), `tmo_flag_o` becomes 1 at the 64th rising edge after the edge that put a word into an empty queue, provided no pop occurs in between. After the 63rd such edge it is still 0.
- R6: With `slave_mode_i` = 1 (slave), the same rule applies with 576 edges in place of 64.
- R7: The unread-time count restarts at every accepted pop and stays at zero while the queue is empty, so an empty queue never raises `tmo_flag_o`. Once a timeout has been flagged, the next one needs a pop or an empty queue first.
- R8: `ovr_flag_o` and `tmo_flag_o` stay set until a 1 is applied on `ovr_clr_i` or `tmo_clr_i` respectively for one cycle. The flag reads 0 after that edge, unless a new event occurs in the same cycle.
- R9: `irq_o` is 1 exactly when (`ovr_flag_o` and `ovr_ien_i`) or (`tmo_flag_o` and `tmo_ien_i`).
- R10: A pop while empty, with no push in the same cycle, leaves the queue empty and does not change either flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Completed word strobe from the shift logic |
| push_data_i | input | DW | Word to store |
| pop_i | input | 1 | Read strobe; consumes the oldest word |
| pop_data_o | output | DW | Oldest stored word |
| slave_mode_i | input | 1 | 0 = master (64-clock limit), 1 = slave (576-clock limit) |
| ovr_ien_i | input | 1 | Overrun interrupt enable |
| tmo_ien_i | input | 1 | Timeout interrupt enable |
| ovr_clr_i | input | 1 | Write-1 clear of the overrun flag |
| tmo_clr_i | input | 1 | Write-1 clear of the timeout flag |
| level_o | output | $clog2(DEPTH+1) | Number of stored words |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No stored word |
| ovr_flag_o | output | 1 | Sticky overrun flag |
| tmo_flag_o | output | 1 | Sticky unread-data timeout flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest condition to reach is the exact timeout boundary after a pop restart. The stimulus has to leave one word stored, pop another so that the count restarts mid-wait, and then sample the flag one edge before and at the 64th edge counted from that pop. The bench gets there by pushing two words and idling long enough that the first timeout has already been flagged and cleared. It then pops one word and counts edges from the pop. The slave limit is reached the same way, with a 576-edge wait.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic {
        RXQ_MASTER = 1'b0,
        RXQ_SLAVE  = 1'b1
    } rxq_mode_e;

    localparam int unsigned RXQ_MST_WAIT = 64;
    localparam int unsigned RXQ_SLV_WAIT = 576;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  logic [DW-1:0]                wdata_i,
    input  logic                         pop_i,
    output logic [DW-1:0]                rdata_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o,
    output logic                         full_o,
    output logic                         empty_o,
    output logic                         ovr_evt_o,
    output logic                         pop_evt_o
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [LW-1:0] lvl;
    } ptr_t;

    ptr_t st_q, st_d;
    logic do_push, do_pop;
    logic [DW-1:0] slot [DEPTH];

    assign full_o  = (st_q.lvl == LW'(DEPTH));
    assign empty_o = (st_q.lvl == '0);

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && !empty_o;
        do_push = push_i && (!full_o || do_pop);
        if (do_push) begin
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.lvl = st_q.lvl + LW'(1);
            2'b01:   st_d.lvl = st_q.lvl - LW'(1);
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [DW-1:0] word_q;
        always_ff @(posedge clk) begin
            if (do_push && (st_q.wr == AW'(g))) begin
                word_q <= wdata_i;
            end
        end
        assign slot[g] = word_q;
    end

    assign rdata_o   = slot[st_q.rd];
    assign level_o   = st_q.lvl;
    assign ovr_evt_o = push_i && full_o && !pop_i;
    assign pop_evt_o = do_pop;

endmodule

// File: rtl/rxq_tmo.sv
module rxq_tmo
    import rxq_pkg::*;
#(
    parameter int unsigned MST_WAIT = RXQ_MST_WAIT,
    parameter int unsigned SLV_WAIT = RXQ_SLV_WAIT
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      occupied_i,
    input  logic      restart_i,
    input  rxq_mode_e mode_i,
    output logic      hit_o
);
    localparam int unsigned MAXW = (SLV_WAIT > MST_WAIT) ? SLV_WAIT : MST_WAIT;
    localparam int unsigned CW   = $clog2(MAXW + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          fired;
    } tmo_t;

    tmo_t st_q, st_d;
    logic [CW-1:0] limit;

    always_comb begin
        st_d  = st_q;
        hit_o = 1'b0;
        limit = (mode_i == RXQ_SLAVE) ? CW'(SLV_WAIT) : CW'(MST_WAIT);
        if (!occupied_i || restart_i) begin
            st_d = '0;
        end else begin
            if (st_q.cnt != CW'(MAXW)) begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
            if (!st_q.fired && (st_d.cnt >= limit)) begin
                hit_o      = 1'b1;
                st_d.fired = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH    = 8,
    parameter int unsigned DW       = 8,
    parameter int unsigned MST_WAIT = RXQ_MST_WAIT,
    parameter int unsigned SLV_WAIT = RXQ_SLV_WAIT
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push_i,
    input  logic [DW-1:0]               push_data_i,
    input  logic                        pop_i,
    output logic [DW-1:0]               pop_data_o,
    input  logic                        slave_mode_i,
    input  logic                        ovr_ien_i,
    input  logic                        tmo_ien_i,
    input  logic                        ovr_clr_i,
    input  logic                        tmo_clr_i,
    output logic [$clog2(DEPTH+1)-1:0]  level_o,
    output logic                        full_o,
    output logic                        empty_o,
    output logic                        ovr_flag_o,
    output logic                        tmo_flag_o,
    output logic                        irq_o
);
    typedef struct packed {
        logic ovr;
        logic tmo;
    } flag_t;

    flag_t fl_q, fl_d;
    logic  ovr_evt, pop_evt, tmo_hit;

    rxq_store #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push_i),
        .wdata_i   (push_data_i),
        .pop_i     (pop_i),
        .rdata_o   (pop_data_o),
        .level_o   (level_o),
        .full_o    (full_o),
        .empty_o   (empty_o),
        .ovr_evt_o (ovr_evt),
        .pop_evt_o (pop_evt)
    );

    rxq_tmo #(
        .MST_WAIT (MST_WAIT),
        .SLV_WAIT (SLV_WAIT)
    ) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .occupied_i (!empty_o),
        .restart_i  (pop_evt),
        .mode_i     (rxq_mode_e'(slave_mode_i)),
        .hit_o      (tmo_hit)
    );

    always_comb begin
        fl_d.ovr = (fl_q.ovr && !ovr_clr_i) || ovr_evt;
        fl_d.tmo = (fl_q.tmo && !tmo_clr_i) || tmo_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign ovr_flag_o = fl_q.ovr;
    assign tmo_flag_o = fl_q.tmo;
    assign irq_o      = (fl_q.ovr && ovr_ien_i) || (fl_q.tmo && tmo_ien_i);

endmodule

// File: rtl/rxq_fifo_chk.sv
module rxq_fifo_chk #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        push_i,
    input logic                        pop_i,
    input logic [DW-1:0]               pop_data_o,
    input logic                        ovr_ien_i,
    input logic                        tmo_ien_i,
    input logic                        ovr_clr_i,
    input logic                        tmo_clr_i,
    input logic [$clog2(DEPTH+1)-1:0]  level_o,
    input logic                        full_o,
    input logic                        empty_o,
    input logic                        ovr_flag_o,
    input logic                        tmo_flag_o,
    input logic                        irq_o
);
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level_o <= DEPTH);

    assert_full_needs_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(push_i));

    assert_drop_on_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (full_o && ovr_flag_o && $stable(pop_data_o)));

    assert_pushpop_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && full_o && !ovr_flag_o) |=> (full_o && !ovr_flag_o));

    assert_no_tmo_from_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o |=> !$rose(tmo_flag_o));

    assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag_o && !ovr_clr_i) |=> ovr_flag_o);

    assert_tmo_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag_o && !tmo_clr_i) |=> tmo_flag_o);

    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_ien_i && !tmo_ien_i) |-> !irq_o);

    assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i && !ovr_clr_i && !tmo_clr_i)
            |=> (empty_o && $stable(ovr_flag_o) && $stable(tmo_flag_o)));

endmodule

bind rxq_fifo rxq_fifo_chk #(
    .DEPTH (DEPTH),
    .DW    (DW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .pop_data_o (pop_data_o),
    .ovr_ien_i  (ovr_ien_i),
    .tmo_ien_i  (tmo_ien_i),
    .ovr_clr_i  (ovr_clr_i),
    .tmo_clr_i  (tmo_clr_i),
    .level_o    (level_o),
    .full_o     (full_o),
    .empty_o    (empty_o),
    .ovr_flag_o (ovr_flag_o),
    .tmo_flag_o (tmo_flag_o),
    .irq_o      (irq_o)
);

// File: tb/tb_rxq_fifo.sv
module tb_rxq_fifo;
    localparam int CLK_P = 10;
    localparam int DEPTH = 8;
    localparam int DW    = 8;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          push_i, pop_i, slave_mode_i;
    logic [DW-1:0] push_data_i;
    logic          ovr_ien_i, tmo_ien_i, ovr_clr_i, tmo_clr_i;
    logic [DW-1:0] pop_data_o;
    logic [LW-1:0] level_o;
    logic          full_o, empty_o, ovr_flag_o, tmo_flag_o, irq_o;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_q [$];
    logic          exp_ovr = 1'b0;
    bit            mon_on  = 1'b0;

    rxq_fifo #(.DEPTH(DEPTH), .DW(DW)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .push_i       (push_i),
        .push_data_i  (push_data_i),
        .pop_i        (pop_i),
        .pop_data_o   (pop_data_o),
        .slave_mode_i (slave_mode_i),
        .ovr_ien_i    (ovr_ien_i),
        .tmo_ien_i    (tmo_ien_i),
        .ovr_clr_i    (ovr_clr_i),
        .tmo_clr_i    (tmo_clr_i),
        .level_o      (level_o),
        .full_o       (full_o),
        .empty_o      (empty_o),
        .ovr_flag_o   (ovr_flag_o),
        .tmo_flag_o   (tmo_flag_o),
        .irq_o        (irq_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic ps, input logic [DW-1:0] d, input logic pp);
        @(negedge clk);
        push_i      = ps;
        push_data_i = d;
        pop_i       = pp;
        ovr_clr_i   = 1'b0;
        tmo_clr_i   = 1'b0;
    endtask

    task automatic clear(input logic o, input logic t);
        @(negedge clk);
        push_i    = 1'b0;
        pop_i     = 1'b0;
        ovr_clr_i = o;
        tmo_clr_i = t;
    endtask

    // Monitor / scoreboard: checks outputs against the model, then advances it
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (mon_on) begin
                bit popping, pushing, ovr_set;
                chk(empty_o == (exp_q.size() == 0), "R2 empty", empty_o, exp_q.size() == 0);
                chk(full_o == (exp_q.size() == DEPTH), "R2 full", full_o, exp_q.size() == DEPTH);
                chk(int'(level_o) == exp_q.size(), "R1 level", level_o, exp_q.size());
                chk(ovr_flag_o == exp_ovr, "R3 overrun flag", ovr_flag_o, exp_ovr);
                popping = pop_i && (exp_q.size() > 0);
                pushing = push_i && ((exp_q.size() < DEPTH) || popping);
                ovr_set = push_i && (exp_q.size() == DEPTH) && !pop_i;
                if (popping) begin
                    chk(pop_data_o == exp_q[0], "R1 order", pop_data_o, exp_q[0]);
                    void'(exp_q.pop_front());
                end
                if (pushing) exp_q.push_back(push_data_i);
                exp_ovr = ovr_set || (exp_ovr && !ovr_clr_i);
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; push_i = 1'b0; pop_i = 1'b0; push_data_i = '0;
        slave_mode_i = 1'b0; ovr_ien_i = 1'b0; tmo_ien_i = 1'b0;
        ovr_clr_i = 1'b0; tmo_clr_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        #1;
        chk(empty_o && !full_o, "R2 reset empty", empty_o, 1);
        chk(level_o == 0, "R1 reset level", level_o, 0);
        chk(!ovr_flag_o && !tmo_flag_o, "R8 reset flags", ovr_flag_o | tmo_flag_o, 0);
        chk(!irq_o, "R9 reset irq", irq_o, 0);

        // R10: pop from empty
        step(0, '0, 1);
        step(0, '0, 0);
        #1;
        chk(empty_o, "R10 still empty", empty_o, 1);
        chk(!ovr_flag_o && !tmo_flag_o, "R10 flags unchanged", ovr_flag_o | tmo_flag_o, 0);

        // R2: fill
        for (int i = 0; i < DEPTH; i++) step(1, DW'(8'h10 + i), 0);
        step(0, '0, 0);
        #1 chk(full_o, "R2 full after fill", full_o, 1);

        // R3: extra word dropped
        step(1, 8'hEE, 0);
        step(0, '0, 0);
        #1;
        chk(ovr_flag_o, "R3 overrun set", ovr_flag_o, 1);
        chk(level_o == DEPTH, "R3 level kept", level_o, DEPTH);

        // R8: clear overrun
        clear(1, 0);
        step(0, '0, 0);
        #1 chk(!ovr_flag_o, "R8 overrun cleared", ovr_flag_o, 0);

        // R4: push and pop together while full
        step(1, 8'h40, 1);
        step(0, '0, 0);
        #1 chk(full_o && !ovr_flag_o, "R4 both accepted", {full_o, ovr_flag_o}, 2);

        // drain (monitor checks order, dropped word absent)
        repeat (DEPTH) step(0, '0, 1);
        step(0, '0, 0);
        #1 chk(empty_o, "R1 drained", empty_o, 1);
        clear(0, 1);

        // R5: master timeout boundary
        slave_mode_i = 1'b0;
        step(1, 8'h55, 0);
        step(0, '0, 0);
        repeat (63) @(negedge clk);
        #1 chk(!tmo_flag_o, "R5 edge 63", tmo_flag_o, 0);
        @(negedge clk);
        #1 chk(tmo_flag_o, "R5 edge 64", tmo_flag_o, 1);

        // R9: timeout interrupt gating
        tmo_ien_i = 1'b0;
        #1 chk(!irq_o, "R9 tmo masked", irq_o, 0);
        tmo_ien_i = 1'b1;
        #1 chk(irq_o, "R9 tmo enabled", irq_o, 1);
        tmo_ien_i = 1'b0;

        clear(0, 1);
        step(0, '0, 0);
        #1 chk(!tmo_flag_o, "R8 timeout cleared", tmo_flag_o, 0);

        // R7: pop restarts the count
        step(1, 8'h66, 0);
        repeat (30) step(0, '0, 0);
        step(0, '0, 1);
        step(0, '0, 0);
        repeat (63) @(negedge clk);
        #1 chk(!tmo_flag_o, "R7 restart edge 63", tmo_flag_o, 0);
        @(negedge clk);
        #1 chk(tmo_flag_o, "R7 restart edge 64", tmo_flag_o, 1);

        // R7: empty queue never times out
        clear(0, 1);
        step(0, '0, 1);
        step(0, '0, 0);
        repeat (700) @(negedge clk);
        #1 chk(!tmo_flag_o && empty_o, "R7 empty no timeout", tmo_flag_o, 0);

        // R6: slave timeout boundary
        slave_mode_i = 1'b1;
        step(1, 8'h77, 0);
        step(0, '0, 0);
        repeat (575) @(negedge clk);
        #1 chk(!tmo_flag_o, "R6 edge 575", tmo_flag_o, 0);
        @(negedge clk);
        #1 chk(tmo_flag_o, "R6 edge 576", tmo_flag_o, 1);
        clear(0, 1);
        step(0, '0, 1);
        step(0, '0, 0);
        slave_mode_i = 1'b0;

        // R9: overrun interrupt gating
        for (int i = 0; i < DEPTH; i++) step(1, DW'(8'h80 + i), 0);
        step(1, 8'hEF, 0);
        step(0, '0, 0);
        #1;
        ovr_ien_i = 1'b0;
        #1 chk(!irq_o, "R9 ovr masked", irq_o, 0);
        ovr_ien_i = 1'b1;
        #1 chk(irq_o, "R9 ovr enabled", irq_o, 1);
        clear(1, 0);
        step(0, '0, 0);
        #1 chk(!irq_o && !ovr_flag_o, "R8 ovr clear drops irq", irq_o, 0);
        ovr_ien_i = 1'b0;
        repeat (DEPTH) step(0, '0, 1);
        step(0, '0, 0);
        #1 chk(empty_o, "R1 final drain", empty_o, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule